// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a parameterised set of interrupt request lines, holds a per-source enable mask, keeps a sticky pending flag for each edge-type source, and picks the winning request by fixed priority. The winner is the lowest source index. It presents a registered request strobe and a vector index to a small CPU core. The core answers with an acknowledge strobe in the cycle it accepts the vector.

Each source is either an edge source or a level source, set by a compile-time mask. An edge source latches a flag on the rising edge of its line. A level source has no flag and requests service only while its line is high. The controller also owns the global enable bit. The core drives that bit through three strobes: set-enable, clear-enable and return-from-interrupt. After a set-enable or a return-from-interrupt, the controller holds off any request until the core reports one completed instruction. A small register port reads the enable mask, the flags and the global enable bit. The same port writes the enable mask and clears flags.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable mask, all flags, the global enable bit and `irq_valid` are zero.
- R2: A rising edge on an edge source sets its flag even while that source or the global enable is off. The flag stays set until it is cleared.
- R3: Writing the flag register (address 1) clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A rising edge in the same cycle as its clear leaves the flag set.
- R4: Level sources (bits set in `LEVEL_MASK`, default bit 7) always read 0 in the flag register. They request only while their line is high and enabled. A level pulse that ends before the source is enabled causes no request.
- R5: `irq_valid` is registered. It rises on the clock edge that samples an enabled pending source while the global enable is 1 and no hold-off is active. `irq_vec` then carries the lowest pending enabled index.
- R6: Acceptance is `ack` with `irq_valid` high and `gie_clr` low. On the next edge the global enable clears, only the flag of `irq_vec` clears, and `irq_valid` falls.
- R7: `gie_set` and `reti` each set the global enable. `irq_valid` then stays low until the edge that samples the first `instr_done` after the strobe.
- R8: `gie_clr` takes effect at once. It blocks an `ack` in the same cycle, so no flag is cleared. The global enable reads 0 and `irq_valid` is low after the next edge.
- R9: When several flags are pending together, they are serviced one per acceptance, in ascending index order.
- R10: Register map, read combinationally on `bus_rdata`: address 0 is the enable mask (read/write), address 1 is the flags (write-one-to-clear), and address 2 returns the global enable in bit 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Raw request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | NSRC | Register write data |
| bus_rdata | output | NSRC | Register read data |
| gie_set | input | 1 | Core executed set-global-enable |
| gie_clr | input | 1 | Core executed clear-global-enable |
| reti | input | 1 | Core executed return-from-interrupt |
| instr_done | input | 1 | Core completed an instruction |
| ack | input | 1 | Core accepts the presented vector |
| irq_valid | output | 1 | Registered interrupt request to the core |
| irq_vec | output | $clog2(NSRC) | Registered winning source index |

## Verification
A wrong flag or enable bit shows up on `bus_rdata` in the same cycle. It also shows up on `irq_vec` or `irq_valid` one edge after the state changes. A broken hold-off or a broken global-enable update shows up as `irq_valid` high one cycle too early, or low one cycle too late, around `reti`, `gie_set` and `instr_done`. A wrong acceptance clear leaves a serviced flag readable, or removes a lower-priority flag, so the next vector after return is wrong or missing.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 8,
  parameter logic [NSRC-1:0] LEVEL_MASK = 8'h80,
  localparam int VW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  input  logic            gie_set,
  input  logic            gie_clr,
  input  logic            reti,
  input  logic            instr_done,
  input  logic            ack,
  output logic            irq_valid,
  output logic [VW-1:0]   irq_vec
);
  localparam logic [NSRC-1:0] EDGE_MASK = ~LEVEL_MASK;
  localparam logic [NSRC-1:0] ONE = {{(NSRC-1){1'b0}}, 1'b1};

  logic [NSRC-1:0] en_q, flag_q, prev_q;
  logic gie_q, hold_q;

  logic [NSRC-1:0] rise, wclr, aclr, en_n, flag_n, pend_n;
  logic accept, gie_n, hold_n, valid_d;
  logic [VW-1:0] vec_d;

  assign accept = ack & irq_valid & ~gie_clr;
  assign rise   = src_in & ~prev_q;
  assign wclr   = (bus_wr && bus_addr == 2'd1) ? bus_wdata : '0;
  assign aclr   = accept ? (ONE << irq_vec) : '0;
  assign en_n   = (bus_wr && bus_addr == 2'd0) ? bus_wdata : en_q;
  assign flag_n = ((flag_q & ~wclr & ~aclr) | rise) & EDGE_MASK;
  assign pend_n = (flag_n | (src_in & LEVEL_MASK)) & en_n;

  always_comb begin
    if (gie_clr || accept) gie_n = 1'b0;
    else if (gie_set || reti) gie_n = 1'b1;
    else gie_n = gie_q;
  end

  always_comb begin
    if ((gie_set || reti) && !gie_clr) hold_n = 1'b1;
    else if (instr_done) hold_n = 1'b0;
    else hold_n = hold_q;
  end

  always_comb begin
    vec_d = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend_n[i]) vec_d = VW'(i);
  end

  assign valid_d = gie_n & ~hold_n & (|pend_n);

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = en_q;
      2'd1:    bus_rdata = flag_q;
      2'd2:    bus_rdata = {{(NSRC-1){1'b0}}, gie_q};
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      flag_q    <= '0;
      prev_q    <= '0;
      gie_q     <= 1'b0;
      hold_q    <= 1'b0;
      irq_valid <= 1'b0;
      irq_vec   <= '0;
    end else begin
      en_q      <= en_n;
      flag_q    <= flag_n;
      prev_q    <= src_in;
      gie_q     <= gie_n;
      hold_q    <= hold_n;
      irq_valid <= valid_d;
      irq_vec   <= vec_d;
    end
  end

  // R6
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!irq_valid && !gie_q));

  // R8
  clear_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> (!gie_q && !irq_valid));

  // R7
  holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gie_set || reti) && !gie_clr) |=> !irq_valid);

  // R5
  vec_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> en_q[irq_vec]);

  // R2
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise & EDGE_MASK)) |=> ((flag_q & $past(rise & EDGE_MASK)) == $past(rise & EDGE_MASK)));

  // R4
  level_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & LEVEL_MASK) == '0);
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] src_in = '0, bus_wdata = '0, bus_rdata;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic gie_set = 0, gie_clr = 0, reti = 0, instr_done = 0, ack = 0;
  logic irq_valid;
  logic [2:0] irq_vec;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti),
    .instr_done(instr_done), .ack(ack), .irq_valid(irq_valid), .irq_vec(irq_vec)
  );

  // {enable, trigger edges, expected vec, expected valid}
  localparam logic [19:0] TBL [6] = '{
    {8'hFF, 8'h01, 3'd0, 1'b1},
    {8'hFF, 8'h48, 3'd3, 1'b1},
    {8'hF0, 8'h0F, 3'd0, 1'b0},
    {8'h0C, 8'h7F, 3'd2, 1'b1},
    {8'h40, 8'h60, 3'd6, 1'b1},
    {8'h00, 8'h7F, 3'd0, 1'b0}
  };

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; cyc(); bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic gie_on();
    gie_set = 1; cyc(); gie_set = 0;
    instr_done = 1; cyc(); instr_done = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) cyc();
    rst_n = 1; #0.5;
    // R1
    check("R1 valid", irq_valid, 0);
    rd(0, r); check("R1 enable", r, 0);
    rd(1, r); check("R1 flags", r, 0);
    rd(2, r); check("R1 gie", r, 0);

    // R10 register map
    wr(0, 8'hA5); rd(0, r); check("R10 enable rw", r, 8'hA5);
    wr(2, 8'h01); rd(2, r); check("R10 gie write ignored", r, 0);
    wr(0, 8'h00);

    // R2 latch while masked
    src_in = 8'h20; cyc(); src_in = 0;
    rd(1, r); check("R2 flag latched masked", r, 8'h20);
    check("R2 no request", irq_valid, 0);
    // R3 write-one-to-clear
    wr(1, 8'hDF); rd(1, r); check("R3 zero bit keeps", r, 8'h20);
    src_in = 8'h20; wr(1, 8'h20); src_in = 0;
    rd(1, r); check("R3 edge beats clear", r, 8'h20);
    wr(1, 8'h20); rd(1, r); check("R3 cleared", r, 0);

    // R5 priority table
    for (int i = 0; i < 6; i++) begin
      wr(1, 8'hFF);
      wr(0, TBL[i][19:12]);
      gie_on();
      src_in = TBL[i][11:4]; cyc(); src_in = 0;
      check($sformatf("R5 valid row%0d", i), irq_valid, TBL[i][0]);
      if (TBL[i][0]) check($sformatf("R5 vec row%0d", i), irq_vec, TBL[i][3:1]);
      gie_clr = 1; cyc(); gie_clr = 0;
    end

    // R4 level source
    wr(1, 8'hFF); wr(0, 8'h80); gie_on();
    src_in = 8'h80; cyc();
    check("R4 level valid", irq_valid, 1);
    check("R4 level vec", irq_vec, 7);
    rd(1, r); check("R4 no flag", r, 0);
    src_in = 0; cyc();
    check("R4 drop", irq_valid, 0);
    wr(0, 8'h00);
    src_in = 8'h80; cyc(); src_in = 0; cyc();
    wr(0, 8'h80); cyc();
    check("R4 gone before enable", irq_valid, 0);

    // R6/R7/R9 accept, return, next in order
    wr(0, 8'hFF); gie_clr = 1; cyc(); gie_clr = 0; gie_on();
    src_in = 8'h12; cyc(); src_in = 0;
    check("R9 first vec", irq_vec, 1);
    check("R5 valid", irq_valid, 1);
    ack = 1; cyc(); ack = 0;
    check("R6 valid drop", irq_valid, 0);
    rd(2, r); check("R6 gie cleared", r, 0);
    rd(1, r); check("R6 only vectored flag", r, 8'h10);
    reti = 1; cyc(); reti = 0;
    check("R7 hold after reti", irq_valid, 0);
    rd(2, r); check("R7 reti sets gie", r, 1);
    instr_done = 1; cyc(); instr_done = 0;
    check("R9 next valid", irq_valid, 1);
    check("R9 next vec", irq_vec, 4);

    // R8 clear beats ack
    gie_clr = 1; ack = 1; cyc(); gie_clr = 0; ack = 0;
    check("R8 valid low", irq_valid, 0);
    rd(2, r); check("R8 gie low", r, 0);
    rd(1, r); check("R8 flag kept", r, 8'h10);

    // R7 set-enable hold-off
    gie_set = 1; cyc(); gie_set = 0;
    check("R7 hold after set", irq_valid, 0);
    instr_done = 1; cyc(); instr_done = 0;
    check("R7 release", irq_valid, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule